// File: doc/BRIEF.md
# Narrow Bus Cycle Sequencer

This block sits between a processor's transfer requests and an external bus that has an 8-bit data path and a 20-bit address. Each request names a cycle type, a size (byte or word), an address operand and, for writes, 16 bits of data. The block runs one external bus cycle for a byte and two ordered bus cycles for a word. Every bus cycle drives the address, an address-latch pulse, the matching strobe and the I/O-versus-memory indication. Writes also drive the outgoing byte. At the end the block returns the assembled read data with a one-clock done pulse.

Addresses follow a separate rule for each cycle type. Memory and fetch cycles use the full 20-bit address. I/O cycles build a 16-bit port number from either a direct 8-bit operand or an indirect 16-bit operand, and always clear the upper address nibble. Interrupt acknowledge cycles carry no meaningful address and exchange data on the low byte lane only.

The controller has five states. `ST_REST` waits for a request. `ST_ADDR`, `ST_STRB`, `ST_DATA` and `ST_IDLE` are the four one-clock phases of a bus cycle. The transitions are:
- REST→ADDR when a legal request is accepted.
- ADDR→STRB, STRB→DATA and DATA→IDLE, one per clock.
- IDLE→ADDR when a second byte remains, with the byte index advanced.
- IDLE→REST after the last byte.

Top module: `nbus_seq`

## Requirements
- R1: The `req_type` codes are 0 memory read, 1 memory write, 2 instruction fetch, 3 I/O read, 4 I/O write and 5 interrupt acknowledge. A request is accepted at a clock edge where the block is in REST, `req_valid`=1 and the code is 0–5. A request with code 6 or 7 is ignored: `busy` stays 0 and no bus cycle starts.
- R2: Every bus cycle lasts exactly four clocks. `bus_ale` is high in the address phase only. The one strobe that matches the type is high in the strobe and data phases only: `bus_rd` for types 0, 2 and 3, `bus_wr` for types 1 and 4, `bus_inta` for type 5. At most one strobe is ever high, and `bus_addr` holds steady while a strobe is high.
- R3: A byte request (`req_word`=0) makes one bus cycle. A word request makes two back-to-back cycles, the first at address X and the second at X+1.
- R4: For read and acknowledge types, `bus_din` is sampled at the end of each data phase. The first byte goes to `rdata[7:0]` and the second byte to `rdata[15:8]`. Bits that are not transferred, and all of `rdata` for write types, read as 0.
- R5: A write drives `wdata[7:0]` on `bus_dout` in the first cycle and `wdata[15:8]` in the second. `bus_doe` is high only while `bus_wr` is high.
- R6: `bus_io` is 1 during every phase of an I/O read or I/O write cycle and 0 during all other cycles. `bus_fetch` is 1 only during instruction fetch cycles.
- R7: I/O cycles drive `bus_addr[19:16]`=0. When `req_ind`=0 the port is `{8'h00, req_addr[7:0]}`. When `req_ind`=1 the port is `req_addr[15:0]`.
- R8: The address of the second byte wraps within 20 bits for memory and fetch cycles, and within 16 bits for I/O cycles, with the upper nibble still 0.
- R9: Interrupt acknowledge cycles drive `bus_addr`=0.
- R10: `busy` is 1 from the clock after acceptance up to and including the clock in which `done` is high. `done` is high for one clock, in the idle phase of the last cycle: 4 clocks after acceptance for a byte and 8 for a word. Requests presented while `busy` is 1 are ignored.
- R11: While reset is held and right after it, `busy`, `done`, `bus_ale` and all strobes are 0 and `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_type | input | 3 | Cycle type code |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | 20 | Memory address or port operand |
| req_ind | input | 1 | I/O port operand is indirect (16 bits) |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data |
| bus_addr | output | 20 | Bus address |
| bus_ale | output | 1 | Address phase marker |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_inta | output | 1 | Interrupt acknowledge strobe |
| bus_io | output | 1 | I/O space indication |
| bus_fetch | output | 1 | Instruction fetch indication |
| bus_dout | output | 8 | Outgoing data byte |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Incoming data byte |

## Verification
The stimulus is seeded random requests over all six types, both sizes and both port modes. The bench answers each bus address with a byte derived from that address, so a swapped byte order or a wrong second address shows up as wrong read data. Directed cases use the top of the 20-bit memory space, the end of the 64 KB port space and port 0xFF, which separate 20-bit wrap, 16-bit wrap and direct-to-indirect carry. Further directed cases send illegal type codes and a second request while busy; both must leave the port activity unchanged.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

    typedef enum logic [2:0] {
        CYC_MRD   = 3'd0,
        CYC_MWR   = 3'd1,
        CYC_FETCH = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_INTA  = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        ST_REST,
        ST_ADDR,
        ST_STRB,
        ST_DATA,
        ST_IDLE
    } st_e;

    function automatic logic cyc_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic cyc_is_io(input cyc_e c);
        return (c == CYC_IORD) || (c == CYC_IOWR);
    endfunction

    function automatic logic cyc_is_wr(input cyc_e c);
        return (c == CYC_MWR) || (c == CYC_IOWR);
    endfunction

    function automatic logic cyc_is_rd(input cyc_e c);
        return (c == CYC_MRD) || (c == CYC_FETCH) || (c == CYC_IORD);
    endfunction

endpackage

// File: rtl/nbus_fsm.sv
module nbus_fsm
    import nbus_pkg::*;
#(
    parameter int BYTES = 2,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_type,
    input  logic             req_word,
    output st_e              state,
    output cyc_e             cyc,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             accept
);

    st_e              state_n;
    logic             word_q;
    logic [IDX_W-1:0] idx_n;

    assign accept = (state == ST_REST) && req_valid && cyc_legal(req_type);
    assign last   = word_q ? (idx == IDX_W'(BYTES - 1)) : (idx == '0);

    always_comb begin
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_REST: begin
                if (accept) begin
                    state_n = ST_ADDR;
                    idx_n   = '0;
                end
            end
            ST_ADDR: state_n = ST_STRB;
            ST_STRB: state_n = ST_DATA;
            ST_DATA: state_n = ST_IDLE;
            ST_IDLE: begin
                if (last) begin
                    state_n = ST_REST;
                end else begin
                    state_n = ST_ADDR;
                    idx_n   = idx + IDX_W'(1);
                end
            end
            default: state_n = ST_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_REST;
            idx    <= '0;
            cyc    <= CYC_MRD;
            word_q <= 1'b0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            if (accept) begin
                cyc    <= cyc_e'(req_type);
                word_q <= req_word;
            end
        end
    end

endmodule

// File: rtl/nbus_addr_gen.sv
module nbus_addr_gen
    import nbus_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PORT_W  = 16,
    parameter int DPORT_W = 8,
    parameter int IDX_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ind,
    input  cyc_e              cyc,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_q;
    logic              ind_q;
    logic [PORT_W-1:0] port_base;
    logic [PORT_W-1:0] port_cur;
    logic [ADDR_W-1:0] mem_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ind_q  <= 1'b0;
        end else if (accept) begin
            base_q <= req_addr;
            ind_q  <= req_ind;
        end
    end

    always_comb begin
        if (ind_q) port_base = base_q[PORT_W-1:0];
        else       port_base = PORT_W'(base_q[DPORT_W-1:0]);
        port_cur = port_base + PORT_W'(idx);
        mem_cur  = base_q + ADDR_W'(idx);
    end

    always_comb begin
        if (cyc == CYC_INTA)    addr = '0;
        else if (cyc_is_io(cyc)) addr = ADDR_W'(port_cur);
        else                     addr = mem_cur;
    end

endmodule

// File: rtl/nbus_lane.sv
module nbus_lane #(
    parameter int DATA_W = 8,
    parameter int BYTES  = 2,
    parameter int IDX_W  = 1,
    localparam int WORD_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  idx,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] dout,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wdata_q <= '0;
        else if (accept) wdata_q <= req_wdata;
    end

    assign dout = wdata_q[idx*DATA_W +: DATA_W];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rdata[g*DATA_W +: DATA_W] <= '0;
            else if (accept)
                rdata[g*DATA_W +: DATA_W] <= '0;
            else if (cap && (idx == IDX_W'(g)))
                rdata[g*DATA_W +: DATA_W] <= bus_din;
        end
    end

endmodule

// File: rtl/nbus_seq.sv
module nbus_seq
    import nbus_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PORT_W  = 16,
    parameter int DPORT_W = 8,
    parameter int DATA_W  = 8,
    parameter int BYTES   = 2,
    localparam int WORD_W = DATA_W * BYTES,
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ind,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_inta,
    output logic              bus_io,
    output logic              bus_fetch,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);

    st_e              state;
    cyc_e             cyc;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             accept;
    logic [ADDR_W-1:0] gen_addr;
    logic             cap;

    nbus_fsm #(.BYTES(BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_word(req_word), .state(state), .cyc(cyc), .idx(idx),
        .last(last), .accept(accept)
    );

    nbus_addr_gen #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DPORT_W(DPORT_W), .IDX_W(IDX_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_ind(req_ind), .cyc(cyc), .idx(idx), .addr(gen_addr)
    );

    assign cap = (state == ST_DATA) && (cyc_is_rd(cyc) || (cyc == CYC_INTA));

    nbus_lane #(.DATA_W(DATA_W), .BYTES(BYTES), .IDX_W(IDX_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_wdata(req_wdata),
        .idx(idx), .cap(cap), .bus_din(bus_din), .dout(bus_dout), .rdata(rdata)
    );

    always_comb begin
        logic strobe;
        busy      = (state != ST_REST);
        strobe    = (state == ST_STRB) || (state == ST_DATA);
        bus_ale   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_inta  = 1'b0;
        bus_doe   = 1'b0;
        done      = 1'b0;
        bus_io    = busy && cyc_is_io(cyc);
        bus_fetch = busy && (cyc == CYC_FETCH);
        bus_addr  = busy ? gen_addr : '0;
        unique case (state)
            ST_REST: ;
            ST_ADDR: bus_ale = 1'b1;
            ST_STRB, ST_DATA: begin
                bus_rd   = strobe && cyc_is_rd(cyc);
                bus_wr   = strobe && cyc_is_wr(cyc);
                bus_inta = strobe && (cyc == CYC_INTA);
                bus_doe  = strobe && cyc_is_wr(cyc);
            end
            ST_IDLE: done = last;
            default: ;
        endcase
    end

endmodule

// File: rtl/nbus_seq_chk.sv
module nbus_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        bus_ale,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_inta,
    input logic        bus_io,
    input logic        bus_doe,
    input logic [19:0] bus_addr
);

    // R2: address phase is followed by a strobe phase
    p_ale_then_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (bus_rd || bus_wr || bus_inta));

    // R2: never two strobes together
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr, bus_inta}));

    // R2: address steady while strobed
    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr || bus_inta) |-> $stable(bus_addr));

    // R5: output enable only with the write strobe
    p_doe_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_wr);

    // R7: I/O cycles clear the upper nibble
    p_io_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> (bus_addr[19:16] == 4'h0));

    // R9: acknowledge carries a zero address
    p_inta_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_inta |-> (bus_addr == 20'h0));

    // R10: done is a single-clock pulse inside busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind nbus_seq nbus_seq_chk u_chk (.*);

// File: tb/sim_nbus_seq.sv
module sim_nbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = 3'd0;
    logic        req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ind = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, bus_ale, bus_rd, bus_wr, bus_inta, bus_io, bus_fetch, bus_doe;
    logic [15:0] rdata;
    logic [19:0] bus_addr;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nbus_seq u0 (.*);

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    assign bus_din = bus_inta ? 8'h5A : mem_byte(bus_addr);

    function automatic logic [19:0] exp_addr(input int t, input logic [19:0] a,
                                             input bit ind, input int k);
        logic [15:0] p;
        if (t == 5) return 20'h0;
        if (t == 3 || t == 4) begin
            p = ind ? a[15:0] : {8'h00, a[7:0]};
            p = p + 16'(k);
            return {4'h0, p};
        end
        return a + 20'(k);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_req(input int t, input bit w, input logic [19:0] a,
                           input bit ind, input logic [15:0] wd, input bit poke);
        int n = 0;
        int nale = 0;
        int done_at = 0;
        int nstr = 0;
        bit kind_ok = 1'b1;
        bit io_ok = 1'b1;
        bit fetch_ok = 1'b1;
        logic [19:0] seen [2];
        logic [7:0]  wb [2];
        logic [15:0] exp_rd;
        int nb = w ? 2 : 1;
        seen[0] = '0; seen[1] = '0; wb[0] = '0; wb[1] = '0;
        @(negedge clk);
        req_valid = 1'b1; req_type = 3'(t); req_word = w;
        req_addr = a; req_ind = ind; req_wdata = wd;
        while (n < 12 && done_at == 0) begin
            @(negedge clk);
            n++;
            if (poke) begin
                req_type = 3'd1; req_word = 1'b0; req_addr = ~a; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            if (bus_io != (t == 3 || t == 4)) io_ok = 1'b0;
            if (bus_fetch != (t == 2)) fetch_ok = 1'b0;
            if (bus_ale) begin
                if (nale < 2) seen[nale] = bus_addr;
                nale++;
            end
            if (bus_rd || bus_wr || bus_inta) begin
                nstr++;
                if (bus_rd != (t == 0 || t == 2 || t == 3)) kind_ok = 1'b0;
                if (bus_wr != (t == 1 || t == 4)) kind_ok = 1'b0;
                if (bus_inta != (t == 5)) kind_ok = 1'b0;
                if (bus_wr && nale >= 1 && nale <= 2) wb[nale-1] = bus_dout;
            end
            if (done) done_at = n;
        end
        req_valid = 1'b0;
        chk(done_at == 4 * nb, "R10 done timing", 32'(done_at), 32'(4 * nb));
        chk(nale == nb, "R3 cycle count", 32'(nale), 32'(nb));
        chk(kind_ok && nstr == 2 * nb, "R2 strobe kind/length", 32'(nstr), 32'(2 * nb));
        chk(io_ok, "R6 io indication", 32'(io_ok), 32'd1);
        chk(fetch_ok, "R6 fetch indication", 32'(fetch_ok), 32'd1);
        for (int k = 0; k < nb; k++) begin
            logic [19:0] ea = exp_addr(t, a, ind, k);
            chk(seen[k] == ea, (t == 5) ? "R9 ack address" :
                (t == 3 || t == 4) ? "R7 R8 io address" : "R3 R8 mem address",
                32'(seen[k]), 32'(ea));
        end
        exp_rd = '0;
        if (t != 1 && t != 4) begin
            for (int k = 0; k < nb; k++)
                exp_rd[k*8 +: 8] = (t == 5) ? 8'h5A : mem_byte(exp_addr(t, a, ind, k));
        end else begin
            for (int k = 0; k < nb; k++)
                chk(wb[k] == wd[k*8 +: 8], "R5 write byte order", 32'(wb[k]), 32'(wd[k*8 +: 8]));
        end
        chk(rdata == exp_rd, "R4 read data", 32'(rdata), 32'(exp_rd));
        @(negedge clk);
        chk(!busy && !bus_ale, "R10 idle after done (busy request ignored)",
            32'({busy, bus_ale}), 32'd0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !bus_ale && !bus_rd && !bus_wr && !bus_inta && bus_addr == 0,
            "R11 reset state", 32'({busy, done, bus_ale, bus_rd, bus_wr, bus_inta}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && bus_addr == 0, "R11 after reset", 32'(busy), 32'd0);

        // R1 illegal codes ignored
        for (int c = 6; c < 8; c++) begin
            req_valid = 1'b1; req_type = 3'(c); req_addr = 20'h12345;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            chk(!busy && !bus_ale && !bus_rd && !bus_wr, "R1 illegal code ignored",
                32'({busy, bus_ale}), 32'd0);
        end

        // directed corners
        run_req(0, 1, 20'hFFFFF, 0, 16'h0, 0);   // R8 20-bit wrap
        run_req(2, 1, 20'h3FFFF, 0, 16'h0, 0);   // R8 carry into nibble, fetch
        run_req(3, 1, 20'hAFFFF, 1, 16'h0, 0);   // R8 16-bit wrap, R7
        run_req(4, 1, 20'h7A0FF, 0, 16'hBEEF, 0); // R7 direct port, carry
        run_req(5, 1, 20'h55555, 0, 16'h0, 0);   // R9
        run_req(1, 1, 20'h01234, 0, 16'hC3A5, 1); // R5, R10 busy ignore
        run_req(0, 0, 20'h8ABCD, 0, 16'h0, 1);   // R10 byte with poke

        // random
        for (int i = 0; i < 60; i++) begin
            run_req(int'($urandom % 6), 1'($urandom), 20'($urandom), 1'($urandom),
                    16'($urandom), 1'($urandom % 4 == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule